// File: doc/BRIEF.md
# Two-Thread Out-of-Order Issue Queue with Per-Thread Reserved Entries

This block is a small issue queue that sits in front of one execution port. It buffers micro-operations from two hardware threads. Each cycle it hands the port at most one operation whose two source operands are both available. Each resident entry records the operation's tag, the thread it belongs to, its two source tags and a ready bit for each source. Results that finish elsewhere are announced on a broadcast bus as a tag. Any pending source that matches the tag becomes ready. Selection looks only at operand readiness and residency time. It never looks at which thread owns an entry.

Admission is where the two threads are kept apart. Each thread has its own enqueue port, and both ports may be accepted in the same cycle. A per-thread acceptance output tells the producer whether an operation offered this cycle is taken. A fixed number of slots, `RSV`, is held back for each thread. A thread that already owns many entries therefore cannot take the last slots the other thread needs to make progress. A per-thread flush removes every entry of one thread and leaves the other thread's entries untouched.

Top module: `smt_issue_queue`

## Requirements
- R1: After reset the queue is empty, `disp_valid` is 0, and both `t0_ok` and `t1_ok` are 1.
- R2: An operation accepted with both sources marked ready is presented on `disp_valid`/`disp_uop`/`disp_tid` in the cycle after the one in which it was accepted.
- R3: A broadcast (`wake_valid` with `wake_tag`) that matches a pending source takes effect in the same cycle. A resident entry can be dispatched in the broadcast cycle, and an operation enqueued in that cycle is stored with that source ready.
- R4: At most one operation is dispatched per cycle. It is the ready entry that has been resident longest, whatever slot it occupies. Of two operations accepted in the same cycle, the thread-0 one counts as older.
- R5: Thread ownership plays no part in selection: an older ready thread-1 entry is dispatched before a younger ready thread-0 entry.
- R6: Both enqueue ports are accepted in the same cycle when at least two slots are free and the rule of R7 holds for each.
- R7: Let free be the count of empty slots and gap(n) = max(0, RSV − n). A thread's offer is accepted only if free − 1 ≥ gap(occupancy of the other thread). With depth 12 and RSV 2, a thread running alone fills 10 slots and its 11th offer is refused.
- R8: A thread that owns fewer than RSV entries always has its offer accepted.
- R9: When only one slot is free and both threads qualify under R7, the thread that owns fewer entries gets the slot and the other is refused.
- R10: A flush with `flush_tid` removes every entry of that thread and no entry of the other thread. No entry of the flushed thread is dispatched in the flush cycle. An operation of the flushed thread accepted in the flush cycle is kept.
- R11: When all slots are occupied, both `t0_ok` and `t1_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t0_valid | input | 1 | Thread 0 offers an operation |
| t0_uop | input | 6 | Thread 0 operation tag |
| t0_src_a | input | 6 | Thread 0 first source tag |
| t0_rdy_a | input | 1 | Thread 0 first source already available |
| t0_src_b | input | 6 | Thread 0 second source tag |
| t0_rdy_b | input | 1 | Thread 0 second source already available |
| t0_ok | output | 1 | Thread 0 offer accepted this cycle |
| t1_valid | input | 1 | Thread 1 offers an operation |
| t1_uop | input | 6 | Thread 1 operation tag |
| t1_src_a | input | 6 | Thread 1 first source tag |
| t1_rdy_a | input | 1 | Thread 1 first source already available |
| t1_src_b | input | 6 | Thread 1 second source tag |
| t1_rdy_b | input | 1 | Thread 1 second source already available |
| t1_ok | output | 1 | Thread 1 offer accepted this cycle |
| wake_valid | input | 1 | A result tag is being broadcast |
| wake_tag | input | 6 | Broadcast result tag |
| flush_valid | input | 1 | Remove all entries of one thread |
| flush_tid | input | 1 | Thread to flush |
| disp_valid | output | 1 | An operation is issued this cycle |
| disp_uop | output | 6 | Tag of the issued operation |
| disp_tid | output | 1 | Thread of the issued operation |

## Verification
The hardest state to reach is the contested last slot of R9. Both threads must already own at least `RSV` entries and exactly one slot must remain free. The bench gets there by offering on both ports for five cycles, then on thread 0 alone for one more, with every source tied to a tag that is never broadcast so nothing drains. The age ordering of R4 also needs an older entry to sit in a higher slot than a younger one. The bench arranges this by dispatching the entry in slot 0 before a later arrival refills it.

// File: rtl/smt_iq_pkg.sv
package smt_iq_pkg;

    localparam int TAG_W = 6;
    localparam int AGE_W = 10;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [AGE_W-1:0] age_t;

    typedef struct packed {
        logic live;
        logic tid;
        tag_t uop;
        tag_t src_a;
        tag_t src_b;
        logic rdy_a;
        logic rdy_b;
        age_t age;
    } slot_t;

    // Slots still owed to a thread holding occ entries.
    function automatic int reserve_gap(int occ, int rsv);
        return (occ >= rsv) ? 0 : (rsv - occ);
    endfunction

    function automatic logic tag_hit(logic wv, tag_t wt, tag_t src);
        return wv && (wt == src);
    endfunction

    function automatic age_t age_step(age_t a);
        return (&a) ? a : a + age_t'(1);
    endfunction

    function automatic slot_t fresh_slot(logic tid, tag_t uop, tag_t sa, tag_t sb,
                                         logic ra, logic rb, logic wv, tag_t wt);
        slot_t s;
        s.live  = 1'b1;
        s.tid   = tid;
        s.uop   = uop;
        s.src_a = sa;
        s.src_b = sb;
        s.rdy_a = ra | tag_hit(wv, wt, sa);
        s.rdy_b = rb | tag_hit(wv, wt, sb);
        s.age   = '0;
        return s;
    endfunction

endpackage

// File: rtl/smt_iq_admit.sv
module smt_iq_admit
    import smt_iq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int RSV   = 2,
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] occ0,
    input  logic [CNT_W-1:0] occ1,
    input  logic             want0,
    input  logic             want1,
    output logic             ok0,
    output logic             ok1
);

    int   room;
    logic fit0, fit1, clash, t0_wins;

    always_comb begin
        room    = DEPTH - int'(occ0) - int'(occ1);
        // Taking one slot must leave the other thread's outstanding reserve intact.
        fit0    = room > reserve_gap(int'(occ1), RSV);
        fit1    = room > reserve_gap(int'(occ0), RSV);
        // Both qualify for a single remaining slot: lighter thread wins, thread 0 on a tie.
        clash   = want0 && want1 && fit0 && fit1 && (room < 2);
        t0_wins = occ0 <= occ1;
        ok0     = fit0 && !(clash && !t0_wins);
        ok1     = fit1 && !(clash && t0_wins);
    end

endmodule

// File: rtl/smt_iq_pick.sv
module smt_iq_pick
    import smt_iq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0] req,
    input  age_t             ages [DEPTH],
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    age_t best;

    // Oldest requester wins; strict compare keeps the lower slot on equal age.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i] && (!hit || ages[i] > best)) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                best = ages[i];
            end
        end
    end

endmodule

// File: rtl/smt_iq_vacancy.sv
module smt_iq_vacancy #(
    parameter int DEPTH = 12,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0] vacant,
    output logic [IDX_W-1:0] first,
    output logic [IDX_W-1:0] second
);

    int seen;

    always_comb begin
        first  = '0;
        second = '0;
        seen   = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vacant[i]) begin
                if (seen == 0)      first  = IDX_W'(i);
                else if (seen == 1) second = IDX_W'(i);
                seen = seen + 1;
            end
        end
    end

endmodule

// File: rtl/smt_issue_queue.sv
module smt_issue_queue
    import smt_iq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int RSV   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             t0_valid,
    input  logic [TAG_W-1:0] t0_uop,
    input  logic [TAG_W-1:0] t0_src_a,
    input  logic             t0_rdy_a,
    input  logic [TAG_W-1:0] t0_src_b,
    input  logic             t0_rdy_b,
    output logic             t0_ok,
    input  logic             t1_valid,
    input  logic [TAG_W-1:0] t1_uop,
    input  logic [TAG_W-1:0] t1_src_a,
    input  logic             t1_rdy_a,
    input  logic [TAG_W-1:0] t1_src_b,
    input  logic             t1_rdy_b,
    output logic             t1_ok,
    input  logic             wake_valid,
    input  logic [TAG_W-1:0] wake_tag,
    input  logic             flush_valid,
    input  logic             flush_tid,
    output logic             disp_valid,
    output logic [TAG_W-1:0] disp_uop,
    output logic             disp_tid
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    slot_t            q_view [DEPTH];
    age_t             ages   [DEPTH];
    logic [DEPTH-1:0] vacant;
    logic [DEPTH-1:0] eligible;
    logic [CNT_W-1:0] occ0, occ1;
    logic [IDX_W-1:0] pick_idx, free_a, free_b, slot0, slot1;
    logic             acc0, acc1;

    // Occupancy per thread and readiness including this cycle's broadcast.
    always_comb begin
        occ0 = '0;
        occ1 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            vacant[i]   = !q_view[i].live;
            ages[i]     = q_view[i].age;
            eligible[i] = q_view[i].live
                        && (q_view[i].rdy_a || tag_hit(wake_valid, wake_tag, q_view[i].src_a))
                        && (q_view[i].rdy_b || tag_hit(wake_valid, wake_tag, q_view[i].src_b))
                        && !(flush_valid && q_view[i].tid == flush_tid);
            if (q_view[i].live) begin
                if (q_view[i].tid) occ1 = occ1 + CNT_W'(1);
                else               occ0 = occ0 + CNT_W'(1);
            end
        end
    end

    smt_iq_admit #(.DEPTH(DEPTH), .RSV(RSV), .CNT_W(CNT_W)) u_admit (
        .occ0(occ0), .occ1(occ1), .want0(t0_valid), .want1(t1_valid),
        .ok0(t0_ok), .ok1(t1_ok)
    );

    smt_iq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .req(eligible), .ages(ages), .hit(disp_valid), .idx(pick_idx)
    );

    smt_iq_vacancy #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_vac (
        .vacant(vacant), .first(free_a), .second(free_b)
    );

    assign acc0     = t0_valid && t0_ok;
    assign acc1     = t1_valid && t1_ok;
    assign slot0    = free_a;
    assign slot1    = acc0 ? free_b : free_a;
    assign disp_uop = q_view[pick_idx].uop;
    assign disp_tid = q_view[pick_idx].tid;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t cur, nxt;

        always_comb begin
            nxt = cur;
            if (cur.live) begin
                nxt.age   = age_step(cur.age);
                nxt.rdy_a = cur.rdy_a | tag_hit(wake_valid, wake_tag, cur.src_a);
                nxt.rdy_b = cur.rdy_b | tag_hit(wake_valid, wake_tag, cur.src_b);
            end
            if (disp_valid && pick_idx == IDX_W'(g))           nxt.live = 1'b0;
            if (flush_valid && cur.tid == flush_tid)           nxt.live = 1'b0;
            if (acc0 && slot0 == IDX_W'(g))
                nxt = fresh_slot(1'b0, t0_uop, t0_src_a, t0_src_b, t0_rdy_a, t0_rdy_b,
                                 wake_valid, wake_tag);
            if (acc1 && slot1 == IDX_W'(g))
                nxt = fresh_slot(1'b1, t1_uop, t1_src_a, t1_src_b, t1_rdy_a, t1_rdy_b,
                                 wake_valid, wake_tag);
        end

        always_ff @(posedge clk) begin
            if (rst) cur <= '0;
            else     cur <= nxt;
        end

        assign q_view[g] = cur;
    end

endmodule

// File: rtl/smt_issue_queue_chk.sv
module smt_issue_queue_chk
    import smt_iq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int RSV   = 2,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             t0_valid,
    input logic             t0_ok,
    input logic             t1_valid,
    input logic             t1_ok,
    input logic             flush_valid,
    input logic             flush_tid,
    input logic             disp_valid,
    input logic             disp_tid,
    input logic [CNT_W-1:0] occ0,
    input logic [CNT_W-1:0] occ1
);

    a_r7_reserve_kept: assert property (@(posedge clk) disable iff (rst)
        (DEPTH - int'(occ0) - int'(occ1)) >=
        (reserve_gap(int'(occ0), RSV) + reserve_gap(int'(occ1), RSV)));

    a_r8_t0_reserve_admit: assert property (@(posedge clk) disable iff (rst)
        (t0_valid && int'(occ0) < RSV) |-> t0_ok);

    a_r8_t1_reserve_admit: assert property (@(posedge clk) disable iff (rst)
        (t1_valid && int'(occ1) < RSV) |-> t1_ok);

    a_r9_single_winner: assert property (@(posedge clk) disable iff (rst)
        (t0_valid && t1_valid && (int'(occ0) + int'(occ1) == DEPTH - 1))
        |-> !(t0_ok && t1_ok));

    a_r11_full_refuse: assert property (@(posedge clk) disable iff (rst)
        (int'(occ0) + int'(occ1) == DEPTH) |-> (!t0_ok && !t1_ok));

    a_r10_flush_no_dispatch: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && disp_valid) |-> (disp_tid != flush_tid));

    a_r10_flush_clears_t0: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !flush_tid) |=> (occ0 == CNT_W'($past(t0_valid && t0_ok))));

    a_r10_flush_clears_t1: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_tid) |=> (occ1 == CNT_W'($past(t1_valid && t1_ok))));

endmodule

bind smt_issue_queue smt_issue_queue_chk #(.DEPTH(DEPTH), .RSV(RSV), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .t0_valid(t0_valid), .t0_ok(t0_ok), .t1_valid(t1_valid), .t1_ok(t1_ok),
    .flush_valid(flush_valid), .flush_tid(flush_tid),
    .disp_valid(disp_valid), .disp_tid(disp_tid),
    .occ0(occ0), .occ1(occ1)
);

// File: tb/sim_smt_issue_queue.sv
module sim_smt_issue_queue;
    import smt_iq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic t0_valid, t0_rdy_a, t0_rdy_b, t0_ok;
    logic t1_valid, t1_rdy_a, t1_rdy_b, t1_ok;
    tag_t t0_uop, t0_src_a, t0_src_b, t1_uop, t1_src_a, t1_src_b;
    logic wake_valid, flush_valid, flush_tid, disp_valid, disp_tid;
    tag_t wake_tag, disp_uop;

    smt_issue_queue #(.DEPTH(12), .RSV(2)) u0 (
        .clk(clk), .rst(rst),
        .t0_valid(t0_valid), .t0_uop(t0_uop), .t0_src_a(t0_src_a), .t0_rdy_a(t0_rdy_a),
        .t0_src_b(t0_src_b), .t0_rdy_b(t0_rdy_b), .t0_ok(t0_ok),
        .t1_valid(t1_valid), .t1_uop(t1_uop), .t1_src_a(t1_src_a), .t1_rdy_a(t1_rdy_a),
        .t1_src_b(t1_src_b), .t1_rdy_b(t1_rdy_b), .t1_ok(t1_ok),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .flush_valid(flush_valid), .flush_tid(flush_tid),
        .disp_valid(disp_valid), .disp_uop(disp_uop), .disp_tid(disp_tid)
    );

    localparam tag_t NEVER = 6'd63;

    // {t0 valid, t0 uop, t1 valid, t1 uop, first dispatch, second valid, second dispatch}
    localparam logic [26:0] VEC [4] = '{
        {1'b1, 6'h05, 1'b0, 6'h00, 6'h05, 1'b0, 6'h00},
        {1'b0, 6'h00, 1'b1, 6'h11, 6'h11, 1'b0, 6'h00},
        {1'b1, 6'h21, 1'b1, 6'h22, 6'h21, 1'b1, 6'h22},
        {1'b1, 6'h30, 1'b1, 6'h31, 6'h30, 1'b1, 6'h31}
    };

    int  n_run = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_run++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        t0_valid = 0; t0_uop = '0; t0_src_a = '0; t0_rdy_a = 1; t0_src_b = '0; t0_rdy_b = 1;
        t1_valid = 0; t1_uop = '0; t1_src_a = '0; t1_rdy_a = 1; t1_src_b = '0; t1_rdy_b = 1;
        wake_valid = 0; wake_tag = '0; flush_valid = 0; flush_tid = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        clear_in();
    endtask

    task automatic put0(input tag_t u, input tag_t sa, input logic ra);
        t0_valid = 1; t0_uop = u; t0_src_a = sa; t0_rdy_a = ra;
    endtask

    task automatic put1(input tag_t u, input tag_t sa, input logic ra);
        t1_valid = 1; t1_uop = u; t1_src_a = sa; t1_rdy_a = ra;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(!disp_valid, "R1 no dispatch after reset", disp_valid, 0);
        chk(t0_ok && t1_ok, "R1 both ports open", {t0_ok, t1_ok}, 3);

        // Vector table: ready operations, dispatch order
        for (int v = 0; v < 4; v++) begin
            logic [26:0] w;
            w = VEC[v];
            cyc();
            if (w[26]) put0(w[25:20], 6'd0, 1'b1);
            if (w[19]) put1(w[18:13], 6'd0, 1'b1);
            #1;
            if (w[26]) chk(t0_ok, "R6 t0 accepted", t0_ok, 1);
            if (w[19]) chk(t1_ok, "R6 t1 accepted", t1_ok, 1);
            cyc(); #1;
            chk(disp_valid && disp_uop == w[12:7], "R2 next-cycle dispatch",
                disp_valid ? int'(disp_uop) : -1, int'(w[12:7]));
            cyc(); #1;
            if (w[6]) begin
                chk(disp_valid && disp_uop == w[5:0], "R4 same-cycle pair order",
                    disp_valid ? int'(disp_uop) : -1, int'(w[5:0]));
                cyc(); #1;
            end
            chk(!disp_valid, "R2 queue drained", disp_valid, 0);
        end

        // R5 / R3: older thread-1 entry wins when both woken together
        cyc(); put1(6'h10, 6'd9, 1'b0); #1;
        cyc(); put0(6'h11, 6'd9, 1'b0); #1;
        chk(!disp_valid, "R3 pending sources hold", disp_valid, 0);
        cyc(); wake_valid = 1; wake_tag = 6'd9; #1;
        chk(disp_valid && disp_uop == 6'h10 && disp_tid, "R5 older thread-1 first, R3 same cycle",
            disp_valid ? int'(disp_uop) : -1, 16);
        cyc(); #1;
        chk(disp_valid && disp_uop == 6'h11, "R3 woken entry kept ready",
            disp_valid ? int'(disp_uop) : -1, 17);
        cyc(); #1;

        // R3: wakeup in the enqueue cycle is captured
        cyc(); put0(6'h12, 6'd12, 1'b0); wake_valid = 1; wake_tag = 6'd12; #1;
        chk(!disp_valid, "R3 not resident yet", disp_valid, 0);
        cyc(); #1;
        chk(disp_valid && disp_uop == 6'h12, "R3 wake at enqueue captured",
            disp_valid ? int'(disp_uop) : -1, 18);
        cyc(); #1;

        // R4: age beats slot position
        cyc(); put0(6'h20, 6'd4, 1'b0); #1;
        cyc(); put0(6'h21, 6'd5, 1'b0); #1;
        cyc(); wake_valid = 1; wake_tag = 6'd4; #1;
        chk(disp_valid && disp_uop == 6'h20, "R4 first woken", disp_valid ? int'(disp_uop) : -1, 32);
        cyc(); put1(6'h22, 6'd5, 1'b0); #1;
        cyc(); wake_valid = 1; wake_tag = 6'd5; #1;
        chk(disp_valid && disp_uop == 6'h21, "R4 older in higher slot wins",
            disp_valid ? int'(disp_uop) : -1, 33);
        cyc(); #1;
        chk(disp_valid && disp_uop == 6'h22, "R4 younger follows",
            disp_valid ? int'(disp_uop) : -1, 34);
        cyc(); #1;
        chk(!disp_valid, "R4 drained", disp_valid, 0);

        // R7: thread 0 alone takes 10 slots
        for (int k = 0; k < 11; k++) begin
            cyc(); put0(tag_t'(k), NEVER, 1'b0); #1;
            chk(t0_ok == (k < 10), "R7 reserve limit", t0_ok, (k < 10) ? 1 : 0);
        end
        // R8: thread 1 still gets its reserve; R11 full
        cyc(); put1(6'h30, NEVER, 1'b0); #1;
        chk(t1_ok, "R8 reserve admit first", t1_ok, 1);
        cyc(); put1(6'h31, NEVER, 1'b0); #1;
        chk(t1_ok, "R8 reserve admit second", t1_ok, 1);
        cyc(); put1(6'h32, NEVER, 1'b0); put0(6'h0b, NEVER, 1'b0); #1;
        chk(!t0_ok && !t1_ok, "R11 full refuses both", {t0_ok, t1_ok}, 0);

        // R10: flush thread 0 while waking everything
        cyc(); flush_valid = 1; flush_tid = 0; wake_valid = 1; wake_tag = NEVER; #1;
        chk(disp_valid && disp_tid && disp_uop == 6'h30, "R10 flushed thread masked",
            disp_valid ? int'(disp_uop) : -1, 48);
        cyc(); #1;
        chk(disp_valid && disp_tid && disp_uop == 6'h31, "R10 other thread kept",
            disp_valid ? int'(disp_uop) : -1, 49);
        cyc(); #1;
        chk(!disp_valid, "R10 thread-0 entries gone", disp_valid, 0);

        // R9: contested last slot
        for (int k = 0; k < 5; k++) begin
            cyc(); put0(tag_t'(k), NEVER, 1'b0); put1(tag_t'(k + 8), NEVER, 1'b0); #1;
            chk(t0_ok && t1_ok, "R6 paired accept", {t0_ok, t1_ok}, 3);
        end
        cyc(); put0(6'h07, NEVER, 1'b0); #1;
        chk(t0_ok, "R7 shared slot accept", t0_ok, 1);
        cyc(); put0(6'h17, NEVER, 1'b0); put1(6'h18, NEVER, 1'b0); #1;
        chk(!t0_ok && t1_ok, "R9 lighter thread wins", {t0_ok, t1_ok}, 1);
        cyc(); flush_valid = 1; flush_tid = 0; #1;
        cyc(); flush_valid = 1; flush_tid = 1; #1;
        cyc(); #1;
        chk(t0_ok && t1_ok && !disp_valid, "R10 both flushes empty queue",
            {t0_ok, t1_ok, disp_valid}, 6);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule